// File: doc/BRIEF.md
# Half-Interval Pre-Emphasis Tap Pulse Generator

This block sits in front of a two-tap serial line driver and decides, tick by tick, when the extra drive stages switch on. It runs on a clock at twice the bit rate, so every clock tick covers half a unit interval. A strobe input marks the tick on which a new bit is presented. The block samples the bit on that tick and passes it to the main driver through a registered data output. If the new bit differs from the previous one, in either direction, the block raises two enables one after the other, each for one tick.

The first enable lasts half a bit and sharpens the edge. The second enable lasts for the half bit that follows and props up the level after the edge, where a lossy line would otherwise let it sag. Each enable has a polarity output that carries the new bit level, so the added current pushes toward the new level.

The same transition also raises a separate pulse for the swing-calibration path. That pulse stays high until a bit is sampled with no change. The block has only these two taps. Any number of independent lanes can be built side by side.

Top module: `hui_preemph_tapgen`

## Requirements
- R1: While `rst` is high at a clock edge, every lane clears `tap1_en`, `tap2_en` and `cal_pulse` to 0 at that edge. The same edge sets `data_out`, `tap1_pol` and `tap2_pol` to the parameter `INIT_LEVEL`.
- R2: `data_in` is sampled only at edges where `bit_strobe` is 1, and `data_out` takes the sampled value at that edge. When `bit_strobe` is 0, changes on `data_in` have no effect on any output.
- R3: At an edge where `bit_strobe` is 1 and `data_in[i]` differs from `data_out[i]`, `tap1_en[i]` goes to 1 for exactly one tick. This holds for rising (0 to 1) and falling (1 to 0) changes alike.
- R4: At an edge where no transition is sampled, `tap1_en[i]` is 0 after that edge. A run of identical bits therefore keeps both taps inactive.
- R5: `tap2_en[i]` is 1 in the tick directly after each tick in which `tap1_en[i]` is 1, and at no other time.
- R6: `tap1_pol[i]` equals the most recently sampled bit. While `tap2_en[i]` is 1, `tap2_pol[i]` equals the bit that started the sequence, so that both polarities reinforce the new level.
- R7: `cal_pulse[i]` is set at every strobed edge that has a transition and cleared at every strobed edge that has none. It holds its value between strobes, so it is high whenever `tap1_en[i]` is high.
- R8: Back-to-back transitions on consecutive bits restart the tap1/tap2 sequence at every bit boundary, and `cal_pulse` stays high across them.
- R9: Lanes are independent: each lane's outputs depend only on its own `data_in` bit and the shared strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_strobe | input | 1 | High on the tick where a new bit is presented |
| data_in | input | LANES | Serial bit per lane |
| data_out | output | LANES | Registered bit to the main driver |
| tap1_en | output | LANES | Edge tap enable, one half-UI |
| tap1_pol | output | LANES | Edge tap polarity |
| tap2_en | output | LANES | Level tap enable, half-UI after tap1 |
| tap2_pol | output | LANES | Level tap polarity |
| cal_pulse | output | LANES | Transition pulse for the calibration path |

## Verification
The bench builds the block with `LANES = 3` and `INIT_LEVEL = 0`. With three lanes, one data word can rise on one lane, fall on another and hold on the third. This makes crosstalk between lanes visible. The stimulus includes ticks with no strobe on which `data_in` toggles, runs of strobes on every tick, long runs of repeated bits and a reset in the middle of a run. These cover the cases where a second edge lands on tap2 and where `cal_pulse` must hold between strobes.

// File: rtl/hui_pkg.sv
package hui_pkg;

  // Registered tap state of one lane
  typedef struct packed {
    logic tap1;
    logic tap2;
    logic pol1;
    logic pol2;
    logic cal;
  } lane_taps_t;

endpackage

// File: rtl/hui_edge_det.sv
module hui_edge_det #(
  parameter bit INIT_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic din,
  output logic level,
  output logic trans
);

  // Level of the last sampled bit
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= INIT_LEVEL;
    end else if (strobe) begin
      level <= din;
    end
  end

  // A change seen on a bit boundary, either direction
  assign trans = strobe && (din != level);

endmodule

// File: rtl/hui_tap_seq.sv
module hui_tap_seq
  import hui_pkg::*;
#(
  parameter bit INIT_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic       din,
  input  logic       trans,
  output lane_taps_t q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q.tap1 <= 1'b0;
      q.tap2 <= 1'b0;
      q.pol1 <= INIT_LEVEL;
      q.pol2 <= INIT_LEVEL;
      q.cal  <= 1'b0;
    end else begin
      // Edge tap: one half-UI right after a sampled change
      q.tap1 <= trans;
      // Level tap: the half-UI that follows the edge tap
      q.tap2 <= q.tap1;
      // Polarity tracks the newest bit; tap2 sees it one tick later
      if (strobe) begin
        q.pol1 <= din;
      end
      q.pol2 <= q.pol1;
      // Calibration pulse covers the whole bit after a change
      if (strobe) begin
        q.cal <= trans;
      end
    end
  end

endmodule

// File: rtl/hui_preemph_tapgen.sv
module hui_preemph_tapgen
  import hui_pkg::*;
#(
  parameter int LANES      = 4,
  parameter bit INIT_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_strobe,
  input  logic [LANES-1:0] data_in,
  output logic [LANES-1:0] data_out,
  output logic [LANES-1:0] tap1_en,
  output logic [LANES-1:0] tap1_pol,
  output logic [LANES-1:0] tap2_en,
  output logic [LANES-1:0] tap2_pol,
  output logic [LANES-1:0] cal_pulse
);

  localparam int LAST_LANE = LANES - 1;

  genvar g;
  generate
    for (g = 0; g <= LAST_LANE; g++) begin : g_lane
      logic       lvl;
      logic       chg;
      lane_taps_t st;

      hui_edge_det #(.INIT_LEVEL(INIT_LEVEL)) u_det (
        .clk    (clk),
        .rst    (rst),
        .strobe (bit_strobe),
        .din    (data_in[g]),
        .level  (lvl),
        .trans  (chg)
      );

      hui_tap_seq #(.INIT_LEVEL(INIT_LEVEL)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .strobe (bit_strobe),
        .din    (data_in[g]),
        .trans  (chg),
        .q      (st)
      );

      assign data_out[g]  = lvl;
      assign tap1_en[g]   = st.tap1;
      assign tap1_pol[g]  = st.pol1;
      assign tap2_en[g]   = st.tap2;
      assign tap2_pol[g]  = st.pol2;
      assign cal_pulse[g] = st.cal;
    end
  endgenerate

endmodule

// File: rtl/hui_preemph_chk.sv
module hui_preemph_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_strobe,
  input logic [LANES-1:0] data_in,
  input logic [LANES-1:0] data_out,
  input logic [LANES-1:0] tap1_en,
  input logic [LANES-1:0] tap1_pol,
  input logic [LANES-1:0] tap2_en,
  input logic [LANES-1:0] tap2_pol,
  input logic [LANES-1:0] cal_pulse
);

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_chk
      AST_TAP1_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tap1_en[i] |-> ($past(bit_strobe) && ($past(data_in[i]) != $past(data_out[i])))); // R3
      AST_NO_EDGE_NO_TAP1: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && (data_in[i] == data_out[i])) |=> !tap1_en[i]); // R4
      AST_TAP2_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        tap1_en[i] |=> tap2_en[i]); // R5
      AST_TAP2_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tap2_en[i] |-> $past(tap1_en[i])); // R5
      AST_POL1_NEW_LEVEL: assert property (@(posedge clk) disable iff (rst)
        tap1_en[i] |-> (tap1_pol[i] == data_out[i])); // R6
      AST_POL2_CARRIED: assert property (@(posedge clk) disable iff (rst)
        tap2_en[i] |-> (tap2_pol[i] == $past(tap1_pol[i]))); // R6
      AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bit_strobe |=> $stable(data_out[i])); // R2
      AST_CAL_WITH_TAP1: assert property (@(posedge clk) disable iff (rst)
        tap1_en[i] |-> cal_pulse[i]); // R7
    end
  endgenerate

endmodule

bind hui_preemph_tapgen hui_preemph_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_hui_preemph_tapgen.sv
`timescale 1ns/1ps
module sim_hui_preemph_tapgen;

  localparam int L = 3;
  localparam bit INIT = 1'b0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bit_strobe = 1'b0;
  logic [L-1:0] data_in = '0;
  logic [L-1:0] data_out, tap1_en, tap1_pol, tap2_en, tap2_pol, cal_pulse;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string ph = "R1 reset";

  // Reference state per lane
  logic  m_lvl [L];
  logic  m_t1  [L];
  logic  m_t2  [L];
  logic  m_p2  [L];
  logic  m_cal [L];
  logic  hist_q [$];  // sampled bits of lane 0, behavioural history

  always #2.5 clk = ~clk;

  hui_preemph_tapgen #(.LANES(L), .INIT_LEVEL(INIT)) u0 (
    .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .data_in(data_in),
    .data_out(data_out), .tap1_en(tap1_en), .tap1_pol(tap1_pol),
    .tap2_en(tap2_en), .tap2_pol(tap2_pol), .cal_pulse(cal_pulse)
  );

  always @(posedge clk) begin
    for (int i = 0; i < L; i++) begin
      if (rst) begin
        m_lvl[i] = INIT; m_t1[i] = 0; m_t2[i] = 0; m_p2[i] = INIT; m_cal[i] = 0;
      end else begin
        logic changed;
        changed = bit_strobe && (data_in[i] != m_lvl[i]);
        m_t2[i] = m_t1[i];
        m_p2[i] = m_lvl[i];
        m_t1[i] = changed;
        if (bit_strobe) begin
          m_cal[i] = changed;
          m_lvl[i] = data_in[i];
        end
      end
    end
    if (!rst && bit_strobe) hist_q.push_back(data_in[0]);
  end

  task automatic chk(input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL [%s] %s got %b expected %b", ph, what, got, exp);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < L; i++) begin
      chk($sformatf("R2 data_out[%0d]", i), data_out[i], m_lvl[i]);
      chk($sformatf("R3 tap1_en[%0d]", i), tap1_en[i], m_t1[i]);
      chk($sformatf("R5 tap2_en[%0d]", i), tap2_en[i], m_t2[i]);
      chk($sformatf("R6 tap1_pol[%0d]", i), tap1_pol[i], m_lvl[i]);
      chk($sformatf("R6 tap2_pol[%0d]", i), tap2_pol[i], m_p2[i]);
      chk($sformatf("R7 cal_pulse[%0d]", i), cal_pulse[i], m_cal[i]);
    end
  endtask

  task automatic step(input logic s, input logic [L-1:0] d);
    @(negedge clk);
    compare_all();
    bit_strobe = s;
    data_in    = d;
  endtask

  // One bit: strobe tick, then a tick where data toggles but must be ignored
  task automatic send_bit(input logic [L-1:0] d);
    step(1'b1, d);
    step(1'b0, ~d);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    ph = "R1 reset";
    step(1'b0, '0); step(1'b1, '1); step(1'b0, '0);
    rst = 1'b0;
    ph = "R4 steady low";
    repeat (4) send_bit('0);
    ph = "R3 rise";
    send_bit('1);
    ph = "R4 steady high";
    repeat (3) send_bit('1);
    ph = "R3 fall";
    send_bit('0);
    ph = "R8 alternate";
    for (int k = 0; k < 8; k++) send_bit((k % 2 == 0) ? '1 : '0);
    ph = "R9 mixed lanes";
    send_bit(3'b101); send_bit(3'b011); send_bit(3'b011); send_bit(3'b110); send_bit(3'b000);
    ph = "R2 no strobe";
    for (int k = 0; k < 10; k++) step(1'b0, L'($urandom));
    ph = "R8 strobe every tick";
    for (int k = 0; k < 12; k++) step(1'b1, L'($urandom));
    ph = "R7 random";
    for (int k = 0; k < 200; k++) step(1'($urandom), L'($urandom));
    ph = "R1 mid reset";
    send_bit('1);
    rst = 1'b1;
    step(1'b0, '1); step(1'b0, '1);
    rst = 1'b0;
    ph = "R3 after reset";
    send_bit('1); send_bit('1);
    step(1'b0, '0);
    if (hist_q.size() == 0) begin
      errors++;
      $display("FAIL [R2] no bits sampled got 0 expected >0");
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL [watchdog] run did not finish got %0d cycles expected <5000", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule